// File: doc/BRIEF.md
# Metering ADC Bring-Up Sequencer

This block takes a multi-channel delta-sigma metering converter from power-on or recalibration to live sampling with no processor involvement. A one-cycle `start` pulse launches a fixed program. On a recalibration it first turns off the clock that is forwarded to the converter's modulator. It then sends a soft-reset command and a series of register writes over a 3-wire SPI link, with chip select driven frame by frame. After the writes it arms a falling-edge detector on the converter's active-low data-ready line, and as the very last step it re-enables the modulator clock.

The SPI shift clock and the modulator clock both run at the rate of the block's own clock. For that reason the block does not toggle clock pins itself. It drives `spi_sck_en` and `adc_clk_en`, which feed clock gates placed outside the block. MOSI changes on the rising edge, and the converter samples it on the falling edge of the gated clock. Register values and per-channel offsets arrive as static inputs. No data stream passes through the block, so there is no valid/ready pair and no back-pressure. Every pin is a plain level or a pulse.

Top module: `adc_cfg_sequencer`

## Requirements
- R1: On a fresh start (`recal`=0), chip select first goes low 2 cycles after the edge that samples `start`, with no clock-disable step. On a recalibration (`recal`=1), `adc_clk_en` is low 2 cycles after that edge, chip select first goes low 3 cycles after it, and `adc_clk_en` stays low for every cycle in which chip select is low.
- R2: Each frame is 24 bits, sent MSB first at one bit per cycle. `spi_sck_en` is high exactly in the cycles in which `spi_cs_n` is low.
- R3: The first frame of every run is the reset command 24'h001100.
- R4: A write frame is {8-bit address, 16-bit value}. Writes follow the reset frame in this order: mode (8'h01), gain (8'h02), detection config (8'h03), channel config n (8'h10+n) for n = 0 to N_CFG-1, clock/oversampling (8'h04), detection threshold (8'h05), then offset n (8'h20+n) in ascending n.
- R5: Offset frames are sent only for channels whose bit is set in CUR_MASK (default 4'b0110). No channel config frame is sent for channel 3 under the default N_CFG=3.
- R6: `irq_hold` rises when a start is accepted, stays high throughout the reset frame, and is low during every later frame.
- R7: Between two frames, chip select stays high for at least 2 cycles.
- R8: Falling edges on `drdy_n` give no `drdy_irq` from the moment a start is accepted until every write has finished. Once armed, each falling edge gives exactly one `drdy_irq` pulse of one cycle.
- R9: `adc_clk_en` rises only after the last frame's chip select has risen. `done` rises exactly one cycle after `adc_clk_en` rises, and it clears when the next start is accepted.
- R10: A `start` pulse that arrives while a run is in progress is ignored. The run keeps its frame list and sends each frame once.
- R11: After reset, `spi_cs_n`=1, `spi_sck_en`=0, `adc_clk_en`=0, `done`=0, `irq_hold`=0 and `drdy_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, also the SPI and modulator clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the bring-up program |
| recal | input | 1 | 1: recalibration path with clock-off step; 0: fresh path |
| mode_val | input | 16 | Mode register value |
| gain_val | input | 16 | Gain register value |
| det_val | input | 16 | Detection configuration value |
| clock_val | input | 16 | Clock/oversampling register value |
| thresh_val | input | 16 | Detection threshold value |
| ch_cfg_val | input | N_CH*16 | Per-channel config values, channel 0 in the low bits |
| ch_ofs_val | input | N_CH*16 | Per-channel offset values, channel 0 in the low bits |
| drdy_n | input | 1 | Asynchronous active-low data-ready from the converter |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck_en | output | 1 | Enable for the external SPI clock gate |
| spi_mosi | output | 1 | Serial data to the converter |
| adc_clk_en | output | 1 | Enable for the external modulator clock gate |
| irq_hold | output | 1 | Interrupt masking request during the reset frame |
| drdy_irq | output | 1 | One-cycle pulse per armed data-ready falling edge |
| done | output | 1 | Bring-up finished, sampling running |

## Verification
The bench targets ordering corners. The first is a data-ready edge that arrives mid-configuration: a design that arms early would raise an interrupt from an unconfigured converter. The second is a recalibration that starts while the modulator clock is running: a design that skips the clock-off step or does it late would let conversions overlap register writes. The bench also counts the frames and the offset channels. A design that ignores the mask or writes channel 3 sends the wrong number of frames. A start that restarts a busy run shows up as duplicated frames. Gap width, bit count and the one-cycle distance between clock enable and `done` are each measured, so an off-by-one in the counters shows as a wrong length.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int FW = AW + DW;

  localparam logic [FW-1:0] RST_FRAME = 24'h001100;

  localparam logic [AW-1:0] A_MODE = 8'h01;
  localparam logic [AW-1:0] A_GAIN = 8'h02;
  localparam logic [AW-1:0] A_DET  = 8'h03;
  localparam logic [AW-1:0] A_CLK  = 8'h04;
  localparam logic [AW-1:0] A_THR  = 8'h05;
  localparam logic [AW-1:0] A_CH0  = 8'h10;
  localparam logic [AW-1:0] A_OFS0 = 8'h20;

  typedef enum logic [2:0] {
    S_IDLE, S_CLKOFF, S_LOAD, S_SHIFT, S_GAP, S_ARM, S_CLKON, S_FIN
  } seq_state_e;
endpackage

// File: rtl/seq_frame_table.sv
module seq_frame_table
  import adc_seq_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int N_CFG = 3,
  parameter logic [N_CH-1:0] CUR_MASK = 4'b0110,
  parameter int IW = 4
) (
  input  logic [IW-1:0]      idx,
  input  logic [DW-1:0]      mode_val,
  input  logic [DW-1:0]      gain_val,
  input  logic [DW-1:0]      det_val,
  input  logic [DW-1:0]      clock_val,
  input  logic [DW-1:0]      thresh_val,
  input  logic [N_CH*DW-1:0] ch_cfg_val,
  input  logic [N_CH*DW-1:0] ch_ofs_val,
  output logic [FW-1:0]      word,
  output logic               valid
);
  localparam int I_CFG0 = 4;
  localparam int I_CLK  = I_CFG0 + N_CFG;
  localparam int I_THR  = I_CLK + 1;
  localparam int I_OFS0 = I_THR + 1;

  always_comb begin
    word  = '0;
    valid = 1'b0;
    if (int'(idx) == 0) begin
      word = RST_FRAME; valid = 1'b1;
    end else if (int'(idx) == 1) begin
      word = {A_MODE, mode_val}; valid = 1'b1;
    end else if (int'(idx) == 2) begin
      word = {A_GAIN, gain_val}; valid = 1'b1;
    end else if (int'(idx) == 3) begin
      word = {A_DET, det_val}; valid = 1'b1;
    end else if (int'(idx) == I_CLK) begin
      word = {A_CLK, clock_val}; valid = 1'b1;
    end else if (int'(idx) == I_THR) begin
      word = {A_THR, thresh_val}; valid = 1'b1;
    end
    for (int c = 0; c < N_CFG; c++) begin
      if (int'(idx) == I_CFG0 + c) begin
        word  = {A_CH0 + AW'(c), ch_cfg_val[c*DW +: DW]};
        valid = 1'b1;
      end
    end
    for (int c = 0; c < N_CH; c++) begin
      if (int'(idx) == I_OFS0 + c) begin
        word  = {A_OFS0 + AW'(c), ch_ofs_val[c*DW +: DW]};
        valid = CUR_MASK[c];
      end
    end
  end
endmodule

// File: rtl/seq_spi_shifter.sv
module seq_spi_shifter #(
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] word,
  output logic          mosi,
  output logic          active,
  output logic          last
);
  localparam int CW = $clog2(FW);

  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      sh     <= word;
      cnt    <= CW'(FW - 1);
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else begin
        sh  <= {sh[FW-2:0], 1'b0};
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign mosi = active & sh[FW-1];
  assign last = active && (cnt == '0);

  // R2: a frame never reloads while bits are still going out
  a_r2_no_reload_midframe: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |-> !load);
endmodule

// File: rtl/seq_drdy_edge.sv
module seq_drdy_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic drdy_n,
  output logic irq
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      irq <= 1'b0;
    end else begin
      s1  <= drdy_n;
      s2  <= s1;
      s3  <= s2;
      irq <= arm & s3 & ~s2;
    end
  end

  // R8: no interrupt unless the detector was armed one cycle earlier
  a_r8_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !irq);
  // R8: each edge gives a single-cycle pulse
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/adc_cfg_sequencer.sv
module adc_cfg_sequencer
  import adc_seq_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int N_CFG = 3,
  parameter logic [N_CH-1:0] CUR_MASK = 4'b0110,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              recal,
  input  logic [15:0]       mode_val,
  input  logic [15:0]       gain_val,
  input  logic [15:0]       det_val,
  input  logic [15:0]       clock_val,
  input  logic [15:0]       thresh_val,
  input  logic [N_CH*16-1:0] ch_cfg_val,
  input  logic [N_CH*16-1:0] ch_ofs_val,
  input  logic              drdy_n,
  output logic              spi_cs_n,
  output logic              spi_sck_en,
  output logic              spi_mosi,
  output logic              adc_clk_en,
  output logic              irq_hold,
  output logic              drdy_irq,
  output logic              done
);
  localparam int N_FR = 6 + N_CFG + N_CH;
  localparam int IW   = $clog2(N_FR + 1);
  localparam int GW   = $clog2(GAP_CYC + 1);

  seq_state_e      st;
  logic [IW-1:0]   idx;
  logic [GW-1:0]   gap;
  logic            armed;
  logic            recal_run;
  logic [FW-1:0]   fr_word;
  logic            fr_valid;
  logic            sh_last;
  logic            sh_active;
  logic            load;

  seq_frame_table #(.N_CH(N_CH), .N_CFG(N_CFG), .CUR_MASK(CUR_MASK), .IW(IW)) u_table (
    .idx(idx), .mode_val(mode_val), .gain_val(gain_val), .det_val(det_val),
    .clock_val(clock_val), .thresh_val(thresh_val),
    .ch_cfg_val(ch_cfg_val), .ch_ofs_val(ch_ofs_val),
    .word(fr_word), .valid(fr_valid)
  );

  assign load = (st == S_LOAD) && (int'(idx) < N_FR) && fr_valid;

  seq_spi_shifter #(.FW(FW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .word(fr_word),
    .mosi(spi_mosi), .active(sh_active), .last(sh_last)
  );

  seq_drdy_edge u_drdy (
    .clk(clk), .rst_n(rst_n), .arm(armed), .drdy_n(drdy_n), .irq(drdy_irq)
  );

  assign spi_sck_en = sh_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; gap <= '0;
      spi_cs_n <= 1'b1; adc_clk_en <= 1'b0; done <= 1'b0;
      irq_hold <= 1'b0; armed <= 1'b0; recal_run <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          done <= 1'b0; armed <= 1'b0; irq_hold <= 1'b1;
          idx <= '0; recal_run <= recal;
          st <= recal ? S_CLKOFF : S_LOAD;
        end
        S_CLKOFF: begin
          adc_clk_en <= 1'b0;
          st <= S_LOAD;
        end
        S_LOAD: begin
          if (int'(idx) >= N_FR) st <= S_ARM;
          else if (!fr_valid) idx <= idx + 1'b1;
          else begin
            spi_cs_n <= 1'b0;
            st <= S_SHIFT;
          end
        end
        S_SHIFT: if (sh_last) begin
          spi_cs_n <= 1'b1;
          if (idx == '0) irq_hold <= 1'b0;
          idx <= idx + 1'b1;
          gap <= GW'(GAP_CYC - 1);
          st <= S_GAP;
        end
        S_GAP: begin
          if (gap == '0) st <= S_LOAD;
          else gap <= gap - 1'b1;
        end
        S_ARM: begin
          armed <= 1'b1;
          st <= S_CLKON;
        end
        S_CLKON: begin
          adc_clk_en <= 1'b1;
          st <= S_FIN;
        end
        S_FIN: begin
          done <= 1'b1; recal_run <= 1'b0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= 2'd3;
    else if (!spi_cs_n) hi_cnt <= '0;
    else if (hi_cnt != 2'd3) hi_cnt <= hi_cnt + 1'b1;
  end

  // R1: modulator clock stays off during recalibration frames
  a_r1_clk_off_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && recal_run) |-> !adc_clk_en);
  // R2: shift clock gate tracks chip select
  a_r2_sck_matches_cs: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck_en == !spi_cs_n);
  // R6: masking only during the reset frame
  a_r6_hold_only_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && idx != '0) |-> !irq_hold);
  // R7: minimum chip-select high time between frames
  a_r7_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> hi_cnt >= 2'd2);
  // R8: detector armed before the clock turns on
  a_r8_armed_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_clk_en) |-> armed);
  // R9: done one cycle after the clock enable
  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_clk_en) |=> $rose(done));
endmodule

// File: tb/adc_cfg_sequencer_test.sv
module adc_cfg_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, recal = 1'b0, drdy_n = 1'b1;
  logic [15:0] mode_val = 16'h0510, gain_val = 16'h0050, det_val = 16'h8853;
  logic [15:0] clock_val = 16'h0F1E, thresh_val = 16'h3880;
  logic [63:0] ch_cfg_val = {16'h1003, 16'h1002, 16'h1001, 16'h1000};
  logic [63:0] ch_ofs_val = {16'h2333, 16'h2222, 16'h2111, 16'h2000};
  logic spi_cs_n, spi_sck_en, spi_mosi, adc_clk_en, irq_hold, drdy_irq, done;

  adc_cfg_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .recal(recal),
    .mode_val(mode_val), .gain_val(gain_val), .det_val(det_val),
    .clock_val(clock_val), .thresh_val(thresh_val),
    .ch_cfg_val(ch_cfg_val), .ch_ofs_val(ch_ofs_val), .drdy_n(drdy_n),
    .spi_cs_n(spi_cs_n), .spi_sck_en(spi_sck_en), .spi_mosi(spi_mosi),
    .adc_clk_en(adc_clk_en), .irq_hold(irq_hold), .drdy_irq(drdy_irq), .done(done)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int pcyc = 0;
  always @(posedge clk) pcyc <= pcyc + 1;

  // expected frame list
  logic [23:0] expf [0:15];
  int n_exp;
  task automatic build_expected();
    n_exp = 0;
    expf[n_exp++] = 24'h001100;
    expf[n_exp++] = {8'h01, mode_val};
    expf[n_exp++] = {8'h02, gain_val};
    expf[n_exp++] = {8'h03, det_val};
    for (int c = 0; c < 3; c++) expf[n_exp++] = {8'h10 + 8'(c), ch_cfg_val[c*16 +: 16]};
    expf[n_exp++] = {8'h04, clock_val};
    expf[n_exp++] = {8'h05, thresh_val};
    expf[n_exp++] = {8'h21, ch_ofs_val[16 +: 16]};
    expf[n_exp++] = {8'h22, ch_ofs_val[32 +: 16]};
  endtask

  // monitor
  logic [23:0] frames [0:31];
  int nbits [0:31];
  logic hold_at [0:31];
  logic [23:0] sh;
  int nf, nb, hi_run, min_gap, sck_bad, clk_in_frame, irq_cnt, irq_wide;
  int first_cs, last_cs_rise, clk_rise, clk_fall, done_rise;
  logic prev_cs = 1'b1, prev_clk = 1'b0, prev_done = 1'b0, prev_irq = 1'b0;

  task automatic clear_mon();
    nf = 0; nb = 0; hi_run = 0; min_gap = 1000; sck_bad = 0; clk_in_frame = 0;
    irq_cnt = 0; irq_wide = 0; first_cs = -1; last_cs_rise = -1;
    clk_rise = -1; clk_fall = -1; done_rise = -1; sh = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!spi_cs_n) begin
        if (prev_cs && nf > 0 && hi_run < min_gap) min_gap = hi_run;
        if (nb == 0) begin
          if (nf < 32) hold_at[nf] = irq_hold;
          if (first_cs < 0) first_cs = pcyc;
        end
        sh = {sh[22:0], spi_mosi};
        nb++;
        if (!spi_sck_en) sck_bad++;
        if (adc_clk_en) clk_in_frame++;
        hi_run = 0;
      end else begin
        if (!prev_cs) begin
          if (nf < 32) begin frames[nf] = sh; nbits[nf] = nb; end
          nf++; nb = 0; last_cs_rise = pcyc;
        end
        if (spi_sck_en) sck_bad++;
        hi_run++;
      end
      if (adc_clk_en && !prev_clk) clk_rise = pcyc;
      if (!adc_clk_en && prev_clk) clk_fall = pcyc;
      if (done && !prev_done) done_rise = pcyc;
      if (drdy_irq) irq_cnt++;
      if (drdy_irq && prev_irq) irq_wide++;
      prev_cs = spi_cs_n; prev_clk = adc_clk_en; prev_done = done; prev_irq = drdy_irq;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic pulse_start(input logic rc, output int t0);
    @(negedge clk);
    t0 = pcyc;
    recal = rc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, "R9 done reached", 32'(done), 1);
    @(negedge clk);
  endtask

  task automatic pulse_drdy();
    @(negedge clk); drdy_n = 1'b0;
    repeat (4) @(negedge clk);
    drdy_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_frames(input string run);
    chk(nf == n_exp, {"R5 frame count ", run}, 32'(nf), 32'(n_exp));
    chk(frames[0] == 24'h001100, {"R3 reset frame ", run}, 32'(frames[0]), 32'h001100);
    for (int i = 1; i < n_exp; i++)
      chk(frames[i] == expf[i], {"R4 frame order ", run}, 32'(frames[i]), 32'(expf[i]));
    for (int i = 0; i < n_exp; i++)
      chk(nbits[i] == 24, {"R2 frame bits ", run}, 32'(nbits[i]), 24);
    chk(sck_bad == 0, {"R2 sck gate ", run}, 32'(sck_bad), 0);
    chk(min_gap >= 2, {"R7 cs gap ", run}, 32'(min_gap), 2);
    chk(hold_at[0] == 1'b1, {"R6 hold in reset frame ", run}, 32'(hold_at[0]), 1);
    chk(hold_at[1] == 1'b0, {"R6 hold after reset frame ", run}, 32'(hold_at[1]), 0);
    chk(clk_rise > last_cs_rise, {"R9 clock after last frame ", run}, 32'(clk_rise), 32'(last_cs_rise));
    chk(done_rise == clk_rise + 1, {"R9 done timing ", run}, 32'(done_rise), 32'(clk_rise + 1));
  endtask

  task automatic t_reset();
    chk(spi_cs_n == 1'b1 && spi_sck_en == 1'b0, "R11 spi idle", {30'd0, spi_cs_n, spi_sck_en}, 32'h2);
    chk(adc_clk_en == 1'b0 && done == 1'b0, "R11 clock and done low", {30'd0, adc_clk_en, done}, 0);
    chk(irq_hold == 1'b0 && drdy_irq == 1'b0, "R11 irq lines low", {30'd0, irq_hold, drdy_irq}, 0);
  endtask

  task automatic t_fresh();
    int t0;
    @(posedge clk); clear_mon();
    pulse_start(1'b0, t0);
    while (nf < 3) @(negedge clk);
    pulse_drdy();
    wait_done();
    chk(first_cs == t0 + 2, "R1 fresh first cs", 32'(first_cs), 32'(t0 + 2));
    chk(irq_cnt == 0, "R8 no irq while configuring", 32'(irq_cnt), 0);
    check_frames("fresh");
    @(posedge clk); irq_cnt = 0; irq_wide = 0;
    pulse_drdy();
    chk(irq_cnt == 1, "R8 one irq per armed edge", 32'(irq_cnt), 1);
    chk(irq_wide == 0, "R8 irq one cycle", 32'(irq_wide), 0);
  endtask

  task automatic t_recal();
    int t0;
    chk(adc_clk_en == 1'b1, "R1 clock running before recal", 32'(adc_clk_en), 1);
    @(posedge clk); clear_mon();
    pulse_start(1'b1, t0);
    chk(done == 1'b0, "R9 done clears on start", 32'(done), 0);
    while (nf < 4) @(negedge clk);
    pulse_drdy();
    wait_done();
    chk(clk_fall == t0 + 2, "R1 recal clock off", 32'(clk_fall), 32'(t0 + 2));
    chk(first_cs == t0 + 3, "R1 recal first cs", 32'(first_cs), 32'(t0 + 3));
    chk(clk_in_frame == 0, "R1 clock off during frames", 32'(clk_in_frame), 0);
    chk(irq_cnt == 0, "R8 disarmed during recal", 32'(irq_cnt), 0);
    check_frames("recal");
  endtask

  task automatic t_busy();
    int t0;
    @(posedge clk); clear_mon();
    pulse_start(1'b1, t0);
    while (nf < 2) @(negedge clk);
    repeat (5) @(negedge clk);
    start = 1'b1; recal = 1'b0;
    @(negedge clk); start = 1'b0;
    while (nf < 7) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk(nf == n_exp, "R10 frame count with busy starts", 32'(nf), 32'(n_exp));
    for (int i = 0; i < n_exp; i++)
      chk(frames[i] == expf[i], "R10 frames unchanged", 32'(frames[i]), 32'(expf[i]));
    chk(clk_in_frame == 0, "R10 clock stayed off", 32'(clk_in_frame), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog act=%0d exp=%0d", pcyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    build_expected();
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fresh();
    t_recal();
    t_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule